// File: doc/BRIEF.md
# Timer Tick Enable Tree

This block produces the per-timer count enables for a bank of five timers. All five run from the peripheral clock. Two shared prescalers slow that clock down. Timers 0 and 1 take their rate from the first prescaler, and timers 2, 3 and 4 take theirs from the second.

Each timer has its own 4-bit source field, which selects one of two sources:
- a power-of-two post-divider applied to its group's prescaled rate, or
- the external tick pin that belongs to its group.

Every output is a single-cycle enable pulse in the peripheral clock domain. No output is a derived clock, so the timers can use it directly as a count enable.

Configuration arrives as two plain words:
- The prescaler word holds the value for group 0 in bits 7:0 and the value for group 1 in bits 15:8.
- The source word gives timer n the field in bits 4n+3:4n.

Top module: `tick_tree`

## Requirements
- R1: While `rst` is high, all `tick_o` bits are 0. Reset clears every prescaler, post-divider and synchronizer register.
- R2: Timers 0 and 1 are paced by the prescaler value in `psc_cfg_i[7:0]`. Timers 2, 3 and 4 are paced by the value in `psc_cfg_i[15:8]`.
- R3: For a source code c in 0..3 and a group prescaler value p, the timer ticks exactly once every (p+1)·2^(c+1) clock cycles in steady state.
- R4: Every tick pulse lasts exactly one clock cycle. Sampled across consecutive cycles with an unchanged source field, `tick_o[n]` is never high twice in a row.
- R5: A source code of 4 or greater (4..15) routes the external tick to the timer. `ext_tick_i[0]` serves timers 0 and 1, and `ext_tick_i[1]` serves timers 2, 3 and 4. A timer in the other group gets no tick from that pin.
- R6: Each rising edge on an external tick pin gives exactly one tick, however long the pin stays high. The tick is high in the cycle that follows the fourth rising clock edge after the pin rises, one cycle after the three-register edge detector.
- R7: Rewriting the source field of one timer does not change the tick spacing of any other timer, including a timer that shares its prescaler.
- R8: A prescaler value of 0 passes every clock cycle, so code 0 with p=0 ticks every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick_i | input | 2 | Asynchronous external tick pins, one per group |
| psc_cfg_i | input | 16 | Prescaler values: group 0 in bits 7:0, group 1 in bits 15:8 |
| sel_cfg_i | input | 20 | Per-timer source codes, timer n in bits 4n+3:4n |
| tick_o | output | 5 | One-cycle tick enables, bit n for timer n |

## Verification
The divider path is driven with random pairs of prescaler values and random codes 0..3 per timer. The bench measures the gap between ticks of timers from both groups, so a wrong group mapping or a wrong exponent shows up as a wrong spacing. Directed cases cover the extremes: p=0 with code 0, and p=255 with code 3. These separate an off-by-one in the prescaler compare from one in the post-divider mask.

The external path is driven with long-held pulses on one pin at a time, using codes 4 and 6. Counting ticks on all five timers shows both the pin-to-group routing and the one-tick-per-edge rule, and the first pulse also checks the exact latency. A source rewrite on timer 0, made while timer 1 is being timed, shows whether the two timers' counters are independent.

// File: rtl/tick_tree_pkg.sv
package tick_tree_pkg;
  localparam int NUM_TIMERS = 5;
  localparam int NUM_GROUPS = 2;
  localparam int PSC_W      = 8;
  localparam int SEL_W      = 4;
  localparam int DIV_STAGES = 4;   // codes 0..3 -> divide by 2..16

  // timers 0,1 -> group 0; timers 2..4 -> group 1
  function automatic int group_of(input int timer_idx);
    return (timer_idx < 2) ? 0 : 1;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc_val,
  output logic             pre_en
);
  logic [PSC_W-1:0] cnt_q;
  logic             hit;

  assign hit = (cnt_q >= psc_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pre_en <= 1'b0;
    end else begin
      cnt_q  <= hit ? '0 : cnt_q + 1'b1;
      pre_en <= hit;
    end
  end

  // R2
  psc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_en && psc_val != '0) |=> (!pre_en || psc_val == '0));
endmodule

// File: rtl/ext_tick_sync.sv
module ext_tick_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic ext_en
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      ext_en <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      ext_en <= s2_q & ~s3_q;
    end
  end

  // R6
  ext_single_chk: assert property (@(posedge clk) disable iff (rst)
    ext_en |=> !ext_en);
endmodule

// File: rtl/tick_post_div.sv
module tick_post_div #(
  parameter int SEL_W      = 4,
  parameter int DIV_STAGES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             pre_en,
  input  logic             ext_en,
  output logic             tick
);
  localparam int EXT_CODE = DIV_STAGES;

  logic [DIV_STAGES-1:0] cnt_q;
  logic [DIV_STAGES-1:0] mask;
  logic                  use_ext;
  logic                  div_hit;

  assign use_ext = (sel >= SEL_W'(EXT_CODE));

  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_STAGES; i++) begin
      if (i <= int'(sel)) mask[i] = 1'b1;
    end
  end

  assign div_hit = pre_en && ((cnt_q | ~mask) == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      if (pre_en) cnt_q <= cnt_q + 1'b1;
      tick <= use_ext ? ext_en : div_hit;
    end
  end

  // R4
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || sel != $past(sel)));
  // R5
  ext_route_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && $past(sel) >= SEL_W'(EXT_CODE)) |-> $past(ext_en));
  // R3
  div_route_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && $past(sel) < SEL_W'(EXT_CODE)) |-> $past(pre_en));
endmodule

// File: rtl/tick_tree.sv
module tick_tree
  import tick_tree_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_GROUPS-1:0]       ext_tick_i,
  input  logic [NUM_GROUPS*PSC_W-1:0] psc_cfg_i,
  input  logic [NUM_TIMERS*SEL_W-1:0] sel_cfg_i,
  output logic [NUM_TIMERS-1:0]       tick_o
);
  logic [NUM_GROUPS-1:0] pre_en;
  logic [NUM_GROUPS-1:0] ext_en;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    tick_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst    (rst),
      .psc_val(psc_cfg_i[g*PSC_W +: PSC_W]),
      .pre_en (pre_en[g])
    );
    ext_tick_sync u_sync (
      .clk   (clk),
      .rst   (rst),
      .pin   (ext_tick_i[g]),
      .ext_en(ext_en[g])
    );
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    localparam int GRP = group_of(t);
    tick_post_div #(.SEL_W(SEL_W), .DIV_STAGES(DIV_STAGES)) u_div (
      .clk   (clk),
      .rst   (rst),
      .sel   (sel_cfg_i[t*SEL_W +: SEL_W]),
      .pre_en(pre_en[GRP]),
      .ext_en(ext_en[GRP]),
      .tick  (tick_o[t])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> tick_o == '0);
endmodule

// File: tb/tb_tick_tree.sv
module tb_tick_tree;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_tick_i = '0;
  logic [15:0] psc_cfg_i = '0;
  logic [19:0] sel_cfg_i = '0;
  logic [4:0]  tick_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tick_tree dut (
    .clk(clk), .rst(rst), .ext_tick_i(ext_tick_i),
    .psc_cfg_i(psc_cfg_i), .sel_cfg_i(sel_cfg_i), .tick_o(tick_o)
  );

  function automatic int exp_period(input int p, input int code);
    return (p + 1) * (1 << (code + 1));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_sel(input int t, input int code);
    sel_cfg_i[t*4 +: 4] = 4'(code);
  endtask

  // wait at negedges for a tick on timer t; returns cycles waited
  task automatic wait_tick(input int t, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!tick_o[t] && cyc < 20000);
  endtask

  // skip two ticks, then measure two intervals, plus width
  task automatic measure(input int t, input int exp, input string req);
    int c;
    wait_tick(t, c);
    wait_tick(t, c);
    for (int k = 0; k < 2; k++) begin
      wait_tick(t, c);
      check(c == exp, req, c, exp);
    end
    @(negedge clk);
    check(tick_o[t] == 1'b0, "R4", int'(tick_o[t]), 0);
  endtask

  // one held pulse on pin g, counting ticks per timer
  task automatic ext_pulse(input int g, input int hold, inout int cnt[5]);
    @(negedge clk);
    ext_tick_i[g] = 1'b1;
    for (int k = 0; k < hold + 8; k++) begin
      @(negedge clk);
      if (k == hold) ext_tick_i[g] = 1'b0;
      for (int t = 0; t < 5; t++) if (tick_o[t]) cnt[t]++;
    end
  endtask

  initial begin
    #(5 * 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    int cnt[5];
    int p0, p1;
    int codes[5];
    void'($urandom(32'd1234));

    // R1: quiet during reset
    psc_cfg_i = '0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(tick_o == 5'b0, "R1", int'(tick_o), 0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R8: p=0, code 0 -> every 2 cycles
    measure(0, 2, "R8");
    measure(3, 2, "R8");

    // R3: extreme p=255 code 3 on group 1
    psc_cfg_i = {8'd255, 8'd0};
    set_sel(2, 3);
    measure(2, exp_period(255, 3), "R3");
    measure(0, exp_period(0, 0), "R2");

    // R2/R3: random configs
    for (int trial = 0; trial < 6; trial++) begin
      p0 = $urandom_range(0, 15);
      p1 = $urandom_range(0, 15);
      psc_cfg_i = {8'(p1), 8'(p0)};
      for (int t = 0; t < 5; t++) begin
        codes[t] = $urandom_range(0, 3);
        set_sel(t, codes[t]);
      end
      measure(1, exp_period(p0, codes[1]), "R2");
      measure(2, exp_period(p1, codes[2]), "R3");
      measure(4, exp_period(p1, codes[4]), "R2");
    end

    // R7: rewrite timer 0 while timing timer 1
    psc_cfg_i = {8'd1, 8'd2};
    set_sel(0, 0);
    set_sel(1, 1);
    measure(1, 12, "R7");
    wait_tick(1, c);
    set_sel(0, 3);
    wait_tick(1, c);
    check(c == 12, "R7", c, 12);
    set_sel(0, 2);
    wait_tick(1, c);
    check(c == 12, "R7", c, 12);

    // R6: latency, pin 0 to timer 0 with code 4
    for (int t = 0; t < 5; t++) set_sel(t, (t < 2) ? 4 : 6);
    repeat (10) @(negedge clk);
    ext_tick_i[0] = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k < 4) check(tick_o[0] == 1'b0, "R6", int'(tick_o[0]), 0);
      else       check(tick_o[0] == 1'b1, "R6", int'(tick_o[0]), 1);
    end
    @(negedge clk);
    check(tick_o[0] == 1'b0, "R4", int'(tick_o[0]), 0);
    repeat (6) @(negedge clk);
    ext_tick_i[0] = 1'b0;
    repeat (6) @(negedge clk);

    // R5/R6: pin 0 pulses, held long
    cnt = '{default: 0};
    for (int k = 0; k < 3; k++) ext_pulse(0, 5 + 7 * k, cnt);
    for (int t = 0; t < 5; t++)
      check(cnt[t] == ((t < 2) ? 3 : 0), "R5", cnt[t], (t < 2) ? 3 : 0);

    // R5: pin 1 pulses with codes 6 (timers 2..4)
    cnt = '{default: 0};
    for (int k = 0; k < 2; k++) ext_pulse(1, 9, cnt);
    for (int t = 0; t < 5; t++)
      check(cnt[t] == ((t < 2) ? 0 : 2), "R5", cnt[t], (t < 2) ? 0 : 2);

    // R1: reset mid-run clears outputs
    psc_cfg_i = '0;
    for (int t = 0; t < 5; t++) set_sel(t, 0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tick_o == 5'b0, "R1", int'(tick_o), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule